// File: doc/BRIEF.md
# Single-Slot Event Timestamp Capture

This block holds one timestamp for each traffic direction (transmit and receive) of a network port. When the MAC datapath pulses the event strobe for a direction, the block copies the free-running time bus into that direction's slot and marks the slot full. From then on the slot is locked. Any further strobe for that direction is dropped until software has collected the stamp, so a stored value always belongs to exactly one frame.

Software sees each slot as three 32-bit words: a control word holding the enable and full flags, the low half of the stamp and the high half of the stamp. Reading the high half is the act that frees the slot. The control word's enable bit decides whether strobes are accepted at all. Clearing the enable bit stops further captures but leaves a captured stamp in place. The register port is a simple read and write strobe interface. Read data is registered and appears one cycle after the read strobe.

Top module: `ts_event_capture`

## Requirements
- R1: After synchronous reset every slot is empty and disabled, its stamp is zero, and `rd_data` is zero.
- R2: A strobe on `evt_strobe[d]` while direction d is enabled and empty stores the value of `time_now` from that cycle. From the next cycle the full flag (control bit 1) reads 1, the low word (select 1) returns bits 31:0 of the stored value and the high word (select 2) returns bits 63:32.
- R3: While a slot is full and not being released, further strobes for that direction leave the stored stamp and the full flag unchanged.
- R4: A read of the high word returns the stored high half and empties the slot. The next read of the control word shows bit 1 as 0.
- R5: Reading the low word, any number of times, leaves the slot full.
- R6: With the enable bit (control bit 0) at 0, a strobe captures nothing and the slot stays empty.
- R7: Writing 0 to the enable bit of a full slot keeps the stamp and the full flag. The stamp can still be read and released.
- R8: If a strobe and a high-word read of the same direction fall in the same cycle on an enabled slot, the read returns the old high half and the new `time_now` value is captured. The slot stays full.
- R9: An address is {direction, select}. Direction 0 is transmit and direction 1 is receive. The select codes are 0 for control, 1 for the low word, 2 for the high word and 3 for an unused code that reads zero. Writes to the control select update bit 0 of that direction only. The two directions never affect each other.
- R10: `rd_data` changes only on the clock edge that follows a cycle with `rd_en` high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 2*WORD_W | Current time value from the time counter |
| evt_strobe | input | NUM_DIR | One-cycle event pulse per direction (bit 0 transmit, bit 1 receive) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NUM_DIR)+2 | Write address {direction, select} |
| wr_data | input | WORD_W | Write data. Bit 0 is the enable for the control select |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | $clog2(NUM_DIR)+2 | Read address {direction, select} |
| rd_data | output | WORD_W | Registered read data, valid one cycle after `rd_en` |

## Verification
The release caused by a high-word read and the capture caused by a new event strobe can land on the same clock edge. The bench provokes this by raising the strobe, with a fresh time value, in the same cycle as the high-word read of a full slot. It judges the outcome at the ports. The returned word must be the old high half, the control word must still show the slot full, and the low and high reads that follow must return the new value. The sweep repeats this for both directions alongside the plain capture, lock, release and disable sequences.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  // Select field (low two address bits) of the register port.
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } ts_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_VLD_BIT = 1;
  localparam int SEL_W        = 2;

endpackage

// File: rtl/ts_slot.sv
// One capture slot: enable flag, full flag and stored stamp.
module ts_slot #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic              release_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              en_o,
  output logic              valid_o,
  output logic [TIME_W-1:0] stamp_o
);

  logic              en_q;
  logic              valid_q;
  logic [TIME_W-1:0] stamp_q;
  logic              slot_free;
  logic              take;

  // A release in the same cycle frees the slot before the event is judged.
  assign slot_free = !valid_q || release_i;
  assign take      = evt_i && en_q && slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      stamp_q <= '0;
    end else begin
      if (en_wr_i) begin
        en_q <= en_val_i;
      end
      if (take) begin
        stamp_q <= time_i;
        valid_q <= 1'b1;
      end else if (release_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign en_o    = en_q;
  assign valid_o = valid_q;
  assign stamp_o = stamp_q;

endmodule

// File: rtl/ts_reg_port.sv
// Address decode, registered read mux, release and enable-write pulses.
module ts_reg_port
  import ts_cap_pkg::*;
#(
  parameter int NUM_DIR = 2,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [WORD_W-1:0]                 wr_data,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic [NUM_DIR-1:0]                en_i,
  input  logic [NUM_DIR-1:0]                valid_i,
  input  logic [NUM_DIR-1:0][2*WORD_W-1:0]  stamp_i,
  output logic [WORD_W-1:0]                 rd_data,
  output logic [NUM_DIR-1:0]                release_o,
  output logic [NUM_DIR-1:0]                en_wr_o,
  output logic                              en_val_o
);

  localparam int DIR_W = ADDR_W - SEL_W;

  ts_sel_e              rd_sel;
  ts_sel_e              wr_sel;
  logic [DIR_W-1:0]     rd_dir;
  logic [DIR_W-1:0]     wr_dir;
  logic [WORD_W-1:0]    rd_mux;
  logic [WORD_W-1:0]    rd_q;

  assign rd_sel = ts_sel_e'(rd_addr[SEL_W-1:0]);
  assign wr_sel = ts_sel_e'(wr_addr[SEL_W-1:0]);
  assign rd_dir = rd_addr[ADDR_W-1:SEL_W];
  assign wr_dir = wr_addr[ADDR_W-1:SEL_W];
  assign en_val_o = wr_data[CTRL_EN_BIT];

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    assign release_o[g] = rd_en && (rd_dir == DIR_W'(g)) && (rd_sel == SEL_HI);
    assign en_wr_o[g]   = wr_en && (wr_dir == DIR_W'(g)) && (wr_sel == SEL_CTRL);
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_DIR; i++) begin
      if (rd_dir == DIR_W'(i)) begin
        unique case (rd_sel)
          SEL_CTRL: begin
            rd_mux[CTRL_EN_BIT]  = en_i[i];
            rd_mux[CTRL_VLD_BIT] = valid_i[i];
          end
          SEL_LO:   rd_mux = stamp_i[i][WORD_W-1:0];
          SEL_HI:   rd_mux = stamp_i[i][2*WORD_W-1:WORD_W];
          SEL_NONE: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_mux;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/ts_event_capture.sv
// Per-direction single-slot timestamp capture with register read port.
module ts_event_capture #(
  parameter int WORD_W  = 32,
  parameter int NUM_DIR = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [2*WORD_W-1:0]            time_now,
  input  logic [NUM_DIR-1:0]             evt_strobe,
  input  logic                           wr_en,
  input  logic [$clog2(NUM_DIR)+1:0]     wr_addr,
  input  logic [WORD_W-1:0]              wr_data,
  input  logic                           rd_en,
  input  logic [$clog2(NUM_DIR)+1:0]     rd_addr,
  output logic [WORD_W-1:0]              rd_data
);

  localparam int TIME_W = 2 * WORD_W;
  localparam int ADDR_W = $clog2(NUM_DIR) + 2;

  logic [NUM_DIR-1:0]             slot_en;
  logic [NUM_DIR-1:0]             slot_valid;
  logic [NUM_DIR-1:0]             slot_rel;
  logic [NUM_DIR-1:0]             slot_en_wr;
  logic                           slot_en_val;
  logic [NUM_DIR-1:0][TIME_W-1:0] slot_stamp;

  ts_reg_port #(
    .NUM_DIR (NUM_DIR),
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W)
  ) i_port (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .en_i      (slot_en),
    .valid_i   (slot_valid),
    .stamp_i   (slot_stamp),
    .rd_data   (rd_data),
    .release_o (slot_rel),
    .en_wr_o   (slot_en_wr),
    .en_val_o  (slot_en_val)
  );

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_slot
    ts_slot #(
      .TIME_W (TIME_W)
    ) i_slot (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (evt_strobe[g]),
      .en_wr_i   (slot_en_wr[g]),
      .en_val_i  (slot_en_val),
      .release_i (slot_rel[g]),
      .time_i    (time_now),
      .en_o      (slot_en[g]),
      .valid_o   (slot_valid[g]),
      .stamp_o   (slot_stamp[g])
    );
  end

endmodule

// File: rtl/ts_event_capture_chk.sv
module ts_event_capture_chk #(
  parameter int NUM_DIR = 2,
  parameter int WORD_W  = 32
) (
  input logic                               clk,
  input logic                               rst,
  input logic [2*WORD_W-1:0]                time_now,
  input logic [NUM_DIR-1:0]                 evt_strobe,
  input logic                               rd_en,
  input logic [WORD_W-1:0]                  rd_data,
  input logic [NUM_DIR-1:0]                 slot_en,
  input logic [NUM_DIR-1:0]                 slot_valid,
  input logic [NUM_DIR-1:0]                 slot_rel,
  input logic [NUM_DIR-1:0][2*WORD_W-1:0]   slot_stamp
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (slot_valid == '0) && (slot_en == '0) && (rd_data == '0));

  p_rdhold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_chk
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
      evt_strobe[g] && slot_en[g] && (!slot_valid[g] || slot_rel[g])
      |=> slot_valid[g] && (slot_stamp[g] == $past(time_now)));

    p_locked_r3: assert property (@(posedge clk) disable iff (rst)
      slot_valid[g] && !slot_rel[g] |=> slot_valid[g] && $stable(slot_stamp[g]));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
      slot_rel[g] && !evt_strobe[g] |=> !slot_valid[g]);

    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
      !slot_en[g] && !slot_valid[g] |=> !slot_valid[g]);

    p_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
      slot_rel[g] && evt_strobe[g] && slot_en[g] |=> slot_valid[g]);
  end

endmodule

bind ts_event_capture ts_event_capture_chk #(
  .NUM_DIR (NUM_DIR),
  .WORD_W  (WORD_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .time_now   (time_now),
  .evt_strobe (evt_strobe),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .slot_en    (slot_en),
  .slot_valid (slot_valid),
  .slot_rel   (slot_rel),
  .slot_stamp (slot_stamp)
);

// File: tb/test_ts_event_capture.sv
module test_ts_event_capture;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int NUM_DIR    = 2;
  localparam int ADDR_W     = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [2*WORD_W-1:0] time_now = '0;
  logic [NUM_DIR-1:0]  evt_strobe = '0;
  logic                wr_en = 1'b0;
  logic [ADDR_W-1:0]   wr_addr = '0;
  logic [WORD_W-1:0]   wr_data = '0;
  logic                rd_en = 1'b0;
  logic [ADDR_W-1:0]   rd_addr = '0;
  logic [WORD_W-1:0]   rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  ts_event_capture #(.WORD_W(WORD_W), .NUM_DIR(NUM_DIR)) i_ts_event_capture (
    .clk        (clk),
    .rst        (rst),
    .time_now   (time_now),
    .evt_strobe (evt_strobe),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp,
                     input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ad(input int dir, input int sel);
    return ADDR_W'((dir << 2) | sel);
  endfunction

  function automatic logic [2*WORD_W-1:0] pat(input int dir, input int k);
    return 64'h0123_4567_89AB_CDEF * (k + 3) + (64'(dir + 1) << 56);
  endfunction

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_event(input int dir, input logic [2*WORD_W-1:0] v);
    @(negedge clk);
    time_now = v; evt_strobe[dir] = 1'b1;
    @(negedge clk);
    evt_strobe = '0;
  endtask

  // Strobe and high-word read of the same direction in one cycle.
  task automatic event_and_hi_read(input int dir, input logic [2*WORD_W-1:0] v,
                                   output logic [WORD_W-1:0] d);
    @(negedge clk);
    time_now = v; evt_strobe[dir] = 1'b1;
    rd_en = 1'b1; rd_addr = ad(dir, 2);
    @(negedge clk);
    evt_strobe = '0; rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [WORD_W-1:0] d;
    logic [2*WORD_W-1:0] v;
    logic [2*WORD_W-1:0] v2;
    repeat (3) @(negedge clk);
    chk(rd_data, '0, "R1 rd_data after reset");
    rst = 1'b0;
    for (int dir = 0; dir < NUM_DIR; dir++) begin
      for (int sel = 0; sel < 4; sel++) begin
        do_read(ad(dir, sel), d);
        chk(d, '0, "R1 reset register");
      end
    end

    for (int dir = 0; dir < NUM_DIR; dir++) begin
      // R6: disabled slot ignores strobes
      do_event(dir, pat(dir, 9));
      do_read(ad(dir, 0), d);
      chk(d, 32'd0, "R6 no capture while disabled");
      do_read(ad(dir, 2), d);
      chk(d, 32'd0, "R6 stamp untouched while disabled");

      do_write(ad(dir, 0), 32'd1);
      do_read(ad(dir, 0), d);
      chk(d, 32'd1, "R9 enable bit written");
      do_read(ad(1 - dir, 0), d);
      chk(d, (dir == 1) ? 32'd1 : 32'd0, "R9 other direction untouched");

      for (int k = 0; k < 4; k++) begin
        v = pat(dir, k);
        do_event(dir, v);
        do_read(ad(dir, 0), d);
        chk(d, 32'd3, "R2 full flag after capture");
        do_read(ad(1 - dir, 0), d);
        chk(d, (dir == 1) ? 32'd1 : 32'd0, "R9 other direction stays empty");
        do_event(dir, ~v);
        do_read(ad(dir, 1), d);
        chk(d, v[31:0], "R3 low word kept after later strobe");
        do_read(ad(dir, 1), d);
        chk(d, v[31:0], "R5 low word reread");
        do_read(ad(dir, 0), d);
        chk(d, 32'd3, "R5 low reads keep slot full");
        do_read(ad(dir, 3), d);
        chk(d, 32'd0, "R9 unused select reads zero");
        do_read(ad(dir, 2), d);
        chk(d, v[63:32], "R4 high word returned");
        repeat (3) @(negedge clk);
        chk(rd_data, v[63:32], "R10 rd_data holds while idle");
        do_read(ad(dir, 0), d);
        chk(d, 32'd1, "R4 slot empty after high read");
      end

      // R7: disabling keeps a captured stamp
      v = pat(dir, 5);
      do_event(dir, v);
      do_write(ad(dir, 0), 32'd0);
      do_read(ad(dir, 0), d);
      chk(d, 32'd2, "R7 full flag kept after disable");
      do_read(ad(dir, 1), d);
      chk(d, v[31:0], "R7 low word kept after disable");
      do_read(ad(dir, 2), d);
      chk(d, v[63:32], "R7 high word readable after disable");
      do_read(ad(dir, 0), d);
      chk(d, 32'd0, "R7 release works while disabled");
      do_event(dir, pat(dir, 6));
      do_read(ad(dir, 0), d);
      chk(d, 32'd0, "R6 no capture after disable");
      do_write(ad(dir, 0), 32'd1);

      // R8: release and capture on the same edge
      for (int k = 0; k < 3; k++) begin
        v  = pat(dir, 10 + k);
        v2 = pat(dir, 20 + k);
        do_event(dir, v);
        event_and_hi_read(dir, v2, d);
        chk(d, v[63:32], "R8 read returns old high half");
        do_read(ad(dir, 0), d);
        chk(d, 32'd3, "R8 slot stays full");
        do_read(ad(dir, 1), d);
        chk(d, v2[31:0], "R8 new low word captured");
        do_read(ad(dir, 2), d);
        chk(d, v2[63:32], "R8 new high word captured");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule